// File: doc/BRIEF.md
# Transmit Timestamp Slot Tracker

This block keeps the books for a pool of hardware timestamp slots that every transmit queue of one port shares. A queue that wants a packet timestamped raises its request line. In the same cycle the block picks one requester, hands it the lowest free slot index and marks that slot busy. If no slot is free it pulses a failure flag instead. The capture hardware writes into whichever slot the request named. It does nothing to keep two packets from using one slot, so the tracker never hands out a slot that is still waiting for its capture.

When the capture side raises an event, the tracker walks the slot indexes in ascending order. For each busy slot whose valid flag is set and whose stored value differs from the last value reported from that slot, it offers the index and the 40-bit value on a valid/ready report port. When the report is accepted it clears that slot's valid flag through a clear strobe and frees the slot. The stored values are read-only and never clear themselves, so a per-slot copy of the last reported value keeps a stale value from being reported twice. A busy slot that has seen a programmable number of timebase ticks is given up as lost: its valid flag is cleared and it is freed without a report. A flush input frees every slot at once and still lets a grant happen in the same cycle.

A four-state machine drives the report and reclaim side:
- IDLE goes to EXPIRE when any busy slot has aged out. Otherwise it goes to SCAN when a capture event is pending.
- SCAN goes to REPORT on a fresh hit. Otherwise it steps to the next index, and from the last index it returns to IDLE.
- REPORT stays put while ready is low. On acceptance it goes back to SCAN at the next index, or to IDLE after the last index.
- EXPIRE always returns to IDLE after one cycle.
- Flush forces IDLE from any state.

Top module: `txts_slot_tracker`

## Requirements
- R1: After reset no slot is busy, `rpt_valid_o`, `clr_stb_o` and `gnt_fail_o` are low, and the first grant returns index 0.
- R2: A grant is combinational in the request cycle. It returns the lowest-numbered slot that is not busy, and that slot is busy from the next cycle on.
- R3: When a request arrives and all slots are busy, `gnt_fail_o` is high in that cycle and `gnt_o` is all zero.
- R4: With several requests in one cycle only the lowest-numbered requester is granted (`gnt_o` bit i set for requester i). The others see no grant that cycle.
- R5: A slot freed in a given cycle (report accepted or expired) is not granted in that same cycle. It can be granted from the next cycle on.
- R6: After a capture event, every busy slot with its valid bit set and a value different from its last reported value is reported in ascending index order. On acceptance `clr_stb_o` pulses with that index and the slot is freed.
- R7: While `rpt_valid_o` is high and `rpt_ready_i` is low, index and value hold steady and the slot stays busy.
- R8: A busy slot whose stored value equals the value last reported from that slot is not reported and stays busy.
- R9: A busy slot that has seen `TIMEOUT_TICKS` ticks of `tick_i` gets a `clr_stb_o` pulse and is freed without any report. Several aged slots are reclaimed lowest index first.
- R10: A flush frees every busy slot. A request in the flush cycle is granted index 0 and does not fail.
- R11: A slot that is not busy is never reported, even with its valid bit set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_i | input | NUM_REQ | One request line per transmit queue |
| gnt_o | output | NUM_REQ | One-hot grant to the winning requester |
| gnt_idx_o | output | log2(NUM_SLOTS) | Slot index handed out |
| gnt_fail_o | output | 1 | Request refused, pool full |
| flush_i | input | 1 | Free all slots |
| tick_i | input | 1 | Timebase tick for slot ageing |
| cap_evt_i | input | 1 | Capture-complete event |
| slot_vld_i | input | NUM_SLOTS | Per-slot capture valid flags |
| slot_ts_i | input | NUM_SLOTS*TS_W | Per-slot stored timestamps, slot i at bits i*TS_W upward |
| clr_stb_o | output | 1 | Clear the valid flag of slot `clr_idx_o` |
| clr_idx_o | output | log2(NUM_SLOTS) | Slot whose valid flag is cleared |
| rpt_valid_o | output | 1 | Report offered |
| rpt_ready_i | input | 1 | Report accepted |
| rpt_idx_o | output | log2(NUM_SLOTS) | Reported slot |
| rpt_ts_o | output | TS_W | Reported timestamp |

## Verification
A busy map that frees a slot too early shows at the very next request, because the grant index drops to the freed slot. A map that never frees a slot makes the grant skip it or fail early. A broken stale-value copy shows within one scan of 64 cycles: either a duplicate report reaches the report port, or an awaited report is missing and the scoreboard is left non-empty. A wrong age counter or a wrong reclaim order shows within the timeout window as a missing or out-of-order clear strobe.

// File: rtl/txts_pkg.sv
package txts_pkg;
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_SCAN   = 2'd1,
        ST_REPORT = 2'd2,
        ST_EXPIRE = 2'd3
    } trk_state_e;
endpackage

// File: rtl/txts_first_one.sv
module txts_first_one #(
    parameter int W = 8,
    localparam int IW = $clog2(W)
) (
    input  logic [W-1:0]  vec,
    output logic          found,
    output logic [IW-1:0] idx
);
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = W - 1; i >= 0; i--) begin
            if (vec[i]) begin
                found = 1'b1;
                idx   = IW'(i);
            end
        end
    end
endmodule

// File: rtl/txts_age_bank.sv
module txts_age_bank #(
    parameter int NUM_SLOTS     = 64,
    parameter int TIMEOUT_TICKS = 2000000,
    localparam int AGE_W = $clog2(TIMEOUT_TICKS + 1)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 tick,
    input  logic [NUM_SLOTS-1:0] busy,
    input  logic [NUM_SLOTS-1:0] restart,
    output logic [NUM_SLOTS-1:0] expired
);
    localparam logic [AGE_W-1:0] LIMIT = AGE_W'(TIMEOUT_TICKS);

    for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_age
        logic [AGE_W-1:0] age_q;

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                age_q <= '0;
            end else if (restart[g]) begin
                age_q <= '0;
            end else if (busy[g] && tick && age_q != LIMIT) begin
                age_q <= age_q + 1'b1;
            end
        end

        assign expired[g] = busy[g] && (age_q == LIMIT);

        // R9: an age never passes the limit
        p_age_bound_r9: assert property (@(posedge clk) disable iff (!rst_n)
            age_q <= LIMIT);
    end
endmodule

// File: rtl/txts_slot_tracker.sv
module txts_slot_tracker
    import txts_pkg::*;
#(
    parameter int NUM_SLOTS     = 64,
    parameter int NUM_REQ       = 4,
    parameter int TS_W          = 40,
    parameter int TICKS_PER_SEC = 1000000,
    parameter int TIMEOUT_TICKS = 2 * TICKS_PER_SEC,
    localparam int IDX_W = $clog2(NUM_SLOTS),
    localparam int RQ_W  = $clog2(NUM_REQ)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [NUM_REQ-1:0]        req_i,
    output logic [NUM_REQ-1:0]        gnt_o,
    output logic [IDX_W-1:0]          gnt_idx_o,
    output logic                      gnt_fail_o,
    input  logic                      flush_i,
    input  logic                      tick_i,
    input  logic                      cap_evt_i,
    input  logic [NUM_SLOTS-1:0]      slot_vld_i,
    input  logic [NUM_SLOTS*TS_W-1:0] slot_ts_i,
    output logic                      clr_stb_o,
    output logic [IDX_W-1:0]          clr_idx_o,
    output logic                      rpt_valid_o,
    input  logic                      rpt_ready_i,
    output logic [IDX_W-1:0]          rpt_idx_o,
    output logic [TS_W-1:0]           rpt_ts_o
);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_SLOTS - 1);

    trk_state_e state_q, state_d;
    logic [NUM_SLOTS-1:0] busy_q, busy_d;
    logic [IDX_W-1:0]     scan_q, scan_d;
    logic [IDX_W-1:0]     exp_q, exp_d;
    logic                 pend_q, pend_d;
    logic [TS_W-1:0]      rpt_ts_q, rpt_ts_d;
    logic [TS_W-1:0]      cache_q [NUM_SLOTS];

    // ---------------- grant side ----------------
    logic                 req_any, free_any, exp_any;
    logic [RQ_W-1:0]      req_win;
    logic [IDX_W-1:0]     free_idx, exp_first;
    logic [NUM_SLOTS-1:0] free_vec, gnt_vec, rel_vec, expired, age_restart;

    assign free_vec = flush_i ? '1 : ~busy_q;

    txts_first_one #(.W(NUM_REQ)) u_req_pick (
        .vec(req_i), .found(req_any), .idx(req_win)
    );
    txts_first_one #(.W(NUM_SLOTS)) u_free_pick (
        .vec(free_vec), .found(free_any), .idx(free_idx)
    );
    txts_first_one #(.W(NUM_SLOTS)) u_exp_pick (
        .vec(expired), .found(exp_any), .idx(exp_first)
    );

    always_comb begin
        gnt_o   = '0;
        gnt_vec = '0;
        if (req_any && free_any) begin
            gnt_o[req_win]    = 1'b1;
            gnt_vec[free_idx] = 1'b1;
        end
    end
    assign gnt_idx_o  = free_idx;
    assign gnt_fail_o = req_any && !free_any;

    // ---------------- scan hit detection ----------------
    logic [TS_W-1:0] cur_ts;
    logic            hit;
    assign cur_ts = slot_ts_i[scan_q*TS_W +: TS_W];
    assign hit    = busy_q[scan_q] && slot_vld_i[scan_q] && (cur_ts != cache_q[scan_q]);

    // ---------------- next-state logic ----------------
    always_comb begin
        state_d  = state_q;
        scan_d   = scan_q;
        exp_d    = exp_q;
        rpt_ts_d = rpt_ts_q;
        pend_d   = pend_q;
        unique case (state_q)
            ST_IDLE: begin
                if (exp_any) begin
                    state_d = ST_EXPIRE;
                    exp_d   = exp_first;
                end else if (pend_q) begin
                    state_d = ST_SCAN;
                    scan_d  = '0;
                    pend_d  = 1'b0;
                end
            end
            ST_SCAN: begin
                if (hit) begin
                    state_d  = ST_REPORT;
                    rpt_ts_d = cur_ts;
                end else if (scan_q == LAST_IDX) begin
                    state_d = ST_IDLE;
                end else begin
                    scan_d = scan_q + 1'b1;
                end
            end
            ST_REPORT: begin
                if (rpt_ready_i) begin
                    if (scan_q == LAST_IDX) begin
                        state_d = ST_IDLE;
                    end else begin
                        state_d = ST_SCAN;
                        scan_d  = scan_q + 1'b1;
                    end
                end
            end
            ST_EXPIRE: state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
        if (cap_evt_i) pend_d = 1'b1;
        if (flush_i) begin
            state_d = ST_IDLE;
            pend_d  = 1'b0;
        end
    end

    // ---------------- outputs ----------------
    logic            rel_en;
    logic [IDX_W-1:0] rel_idx;
    always_comb begin
        rpt_valid_o = (state_q == ST_REPORT);
        rpt_idx_o   = scan_q;
        rpt_ts_o    = rpt_ts_q;
        rel_en      = ((state_q == ST_REPORT) && rpt_ready_i) || (state_q == ST_EXPIRE);
        rel_idx     = (state_q == ST_EXPIRE) ? exp_q : scan_q;
        clr_stb_o   = rel_en;
        clr_idx_o   = rel_idx;
        rel_vec     = '0;
        if (rel_en) rel_vec[rel_idx] = 1'b1;
    end

    always_comb begin
        busy_d = busy_q & ~rel_vec;
        if (flush_i) busy_d = '0;
        busy_d = busy_d | gnt_vec;
    end

    assign age_restart = gnt_vec | rel_vec | {NUM_SLOTS{flush_i}};

    txts_age_bank #(.NUM_SLOTS(NUM_SLOTS), .TIMEOUT_TICKS(TIMEOUT_TICKS)) u_age (
        .clk(clk), .rst_n(rst_n), .tick(tick_i), .busy(busy_q),
        .restart(age_restart), .expired(expired)
    );

    // ---------------- state register ----------------
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= ST_IDLE;
            busy_q   <= '0;
            scan_q   <= '0;
            exp_q    <= '0;
            pend_q   <= 1'b0;
            rpt_ts_q <= '0;
            for (int i = 0; i < NUM_SLOTS; i++) cache_q[i] <= '0;
        end else begin
            state_q  <= state_d;
            busy_q   <= busy_d;
            scan_q   <= scan_d;
            exp_q    <= exp_d;
            pend_q   <= pend_d;
            rpt_ts_q <= rpt_ts_d;
            if ((state_q == ST_REPORT) && rpt_ready_i) cache_q[scan_q] <= rpt_ts_q;
        end
    end

    // ---------------- assertions ----------------
    p_grant_free_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ((|gnt_o) && !flush_i) |-> !busy_q[gnt_idx_o]);
    p_grant_marks_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (|gnt_o) |=> busy_q[$past(gnt_idx_o)]);
    p_fail_full_r3: assert property (@(posedge clk) disable iff (!rst_n)
        gnt_fail_o |-> ((&busy_q) && !(|gnt_o)));
    p_one_winner_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(gnt_o));
    p_no_same_cycle_regrant_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_stb_o && (|gnt_o)) |-> (gnt_idx_o != clr_idx_o));
    p_report_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (rpt_valid_o && !rpt_ready_i && !flush_i) |=>
        (rpt_valid_o && $stable(rpt_idx_o) && $stable(rpt_ts_o)));
    p_report_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
        rpt_valid_o |-> busy_q[rpt_idx_o]);
    p_report_fresh_r8: assert property (@(posedge clk) disable iff (!rst_n)
        rpt_valid_o |-> (rpt_ts_o != cache_q[rpt_idx_o]));
    p_flush_frees_r10: assert property (@(posedge clk) disable iff (!rst_n)
        flush_i |=> ($countones(busy_q) <= 1));
endmodule

// File: tb/txts_slot_tracker_tb.sv
`timescale 1ns/1ps
module txts_slot_tracker_tb;
    localparam int NS = 64;
    localparam int NR = 4;
    localparam int TW = 40;
    localparam int TO = 16;

    typedef struct packed {
        logic [5:0]    idx;
        logic [TW-1:0] ts;
    } rpt_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [NR-1:0] req = '0;
    logic [NR-1:0] gnt;
    logic [5:0]    gnt_idx;
    logic          gnt_fail;
    logic          flush = 1'b0;
    logic          tick = 1'b0;
    logic          cap_evt = 1'b0;
    logic [NS-1:0] slot_vld = '0;
    logic [NS*TW-1:0] slot_ts = '0;
    logic          clr_stb;
    logic [5:0]    clr_idx;
    logic          rpt_valid;
    logic          rpt_ready = 1'b1;
    logic [5:0]    rpt_idx;
    logic [TW-1:0] rpt_ts;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;
    rpt_t exp_q[$];
    int clr_log[$];

    always #2 clk = ~clk;

    txts_slot_tracker #(.NUM_SLOTS(NS), .NUM_REQ(NR), .TS_W(TW), .TIMEOUT_TICKS(TO)) u_dut (
        .clk(clk), .rst_n(rst_n), .req_i(req), .gnt_o(gnt), .gnt_idx_o(gnt_idx),
        .gnt_fail_o(gnt_fail), .flush_i(flush), .tick_i(tick), .cap_evt_i(cap_evt),
        .slot_vld_i(slot_vld), .slot_ts_i(slot_ts), .clr_stb_o(clr_stb),
        .clr_idx_o(clr_idx), .rpt_valid_o(rpt_valid), .rpt_ready_i(rpt_ready),
        .rpt_idx_o(rpt_idx), .rpt_ts_o(rpt_ts)
    );

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    // Monitor: scoreboard of reports and capture-side model of the valid flags
    always @(negedge clk) begin
        rpt_t e;
        #1.5;
        if (rst_n && rpt_valid && rpt_ready) begin
            if (exp_q.size() == 0) begin
                chk(1'b0, "R11 R8 unexpected report", {rpt_idx, rpt_ts}, 64'h0);
            end else begin
                e = exp_q.pop_front();
                chk(rpt_idx == e.idx && rpt_ts == e.ts, "R6 report content", {rpt_idx, rpt_ts}, e);
            end
        end
        if (rst_n && clr_stb) begin
            clr_log.push_back(int'(clr_idx));
            slot_vld[clr_idx] = 1'b0;
        end
    end

    task automatic grant(input int r, input int exp_idx, input string tag);
        @(negedge clk);
        req = NR'(1 << r);
        #1;
        chk(gnt == NR'(1 << r) && gnt_idx == 6'(exp_idx) && !gnt_fail, tag, {gnt, gnt_idx}, {NR'(1 << r), 6'(exp_idx)});
        @(negedge clk);
        req = '0;
    endtask

    task automatic set_slot(input int i, input logic [TW-1:0] v, input logic vld);
        slot_ts[i*TW +: TW] = v;
        slot_vld[i] = vld;
    endtask

    task automatic pulse_evt();
        @(negedge clk);
        cap_evt = 1'b1;
        @(negedge clk);
        cap_evt = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk_clr_log(input int first, input int count, input string tag);
        bit ok = (clr_log.size() == count);
        for (int i = 0; i < clr_log.size() && ok; i++) ok = (clr_log[i] == first + i);
        chk(ok, tag, 64'(clr_log.size()), 64'(count));
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        chk(1'b0, "watchdog expired", 64'h0, 64'h1);
        finish_run();
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1: reset state
        chk(!rpt_valid && !clr_stb && !gnt_fail && gnt == '0, "R1 reset outputs",
            {rpt_valid, clr_stb, gnt_fail, gnt}, 64'h0);
        grant(0, 0, "R1 first grant index");
        grant(2, 1, "R2 lowest free index");
        // R4: two requesters at once
        @(negedge clk);
        req = 4'b1010;
        #1;
        chk(gnt == 4'b0010 && gnt_idx == 6'd2, "R4 lowest requester wins", {gnt, gnt_idx}, {4'b0010, 6'd2});
        @(negedge clk);
        req = '0;
        grant(3, 3, "R2 next grant");

        // R6 / R11: capture event with two fresh busy slots and one idle slot
        set_slot(1, 40'hAA_1111_2222, 1'b1);
        set_slot(0, 40'hBB_3333_4444, 1'b1);
        set_slot(5, 40'hCC_5555_6666, 1'b1);
        exp_q.push_back('{idx: 6'd0, ts: 40'hBB_3333_4444});
        exp_q.push_back('{idx: 6'd1, ts: 40'hAA_1111_2222});
        clr_log.delete();
        pulse_evt();
        idle(150);
        chk(exp_q.size() == 0, "R6 all fresh slots reported", 64'(exp_q.size()), 64'h0);
        chk_clr_log(0, 2, "R6 clear strobes in ascending order");

        // R8: stale value on a regranted slot
        grant(0, 0, "R2 freed slot reused");
        set_slot(0, 40'hBB_3333_4444, 1'b1);
        clr_log.delete();
        pulse_evt();
        idle(100);
        chk(clr_log.size() == 0, "R8 stale slot not cleared", 64'(clr_log.size()), 64'h0);
        grant(1, 1, "R8 stale slot still busy");

        // R7: report held while not ready
        set_slot(0, 40'hDD_7777_8888, 1'b1);
        exp_q.push_back('{idx: 6'd0, ts: 40'hDD_7777_8888});
        rpt_ready = 1'b0;
        pulse_evt();
        for (int i = 0; i < 100 && !rpt_valid; i++) @(negedge clk);
        begin
            bit held = 1'b1;
            for (int i = 0; i < 4; i++) begin
                @(negedge clk);
                #1;
                held = held && rpt_valid && rpt_idx == 6'd0 && rpt_ts == 40'hDD_7777_8888;
            end
            chk(held, "R7 report held stable", {rpt_valid, rpt_idx, rpt_ts}, {1'b1, 6'd0, 40'hDD_7777_8888});
        end
        // R5: release and request in the same cycle
        @(negedge clk);
        rpt_ready = 1'b1;
        req = 4'b0001;
        #1;
        chk(gnt_idx == 6'd4 && gnt == 4'b0001, "R5 released slot not granted same cycle", gnt_idx, 6'd4);
        @(negedge clk);
        #1;
        chk(gnt_idx == 6'd0 && gnt == 4'b0001, "R5 released slot granted next cycle", gnt_idx, 6'd0);
        @(negedge clk);
        req = '0;
        idle(80);
        chk(exp_q.size() == 0, "R6 held report delivered", 64'(exp_q.size()), 64'h0);

        // R9: timeout of busy slots 0..4
        clr_log.delete();
        tick = 1'b1;
        idle(200);
        tick = 1'b0;
        chk_clr_log(0, 5, "R9 aged slots reclaimed lowest first");
        grant(0, 0, "R9 reclaimed slot free");

        // R3: fill the pool
        for (int i = 1; i < NS; i++) grant(i % NR, i, "R2 fill pool");
        @(negedge clk);
        req = 4'b0001;
        #1;
        chk(gnt_fail && gnt == '0, "R3 refuse when full", {gnt_fail, gnt}, {1'b1, 4'b0000});
        @(negedge clk);
        req = '0;

        // R10: flush with a request in the same cycle
        @(negedge clk);
        flush = 1'b1;
        req = 4'b0010;
        #1;
        chk(gnt == 4'b0010 && gnt_idx == 6'd0 && !gnt_fail, "R10 grant during flush", {gnt_fail, gnt, gnt_idx}, {1'b0, 4'b0010, 6'd0});
        @(negedge clk);
        flush = 1'b0;
        req = '0;
        grant(0, 1, "R10 pool freed after flush");
        grant(0, 2, "R10 pool freed after flush");
        idle(4);
        finish_run();
    end
endmodule